// File: doc/BRIEF.md
# Streaming Byte Realignment Unit

This block takes a stream of words that sits at an arbitrary byte offset and returns the same data aligned to word boundaries. Each accepted input word is joined with the word accepted before it. A small index register, set through a write strobe, chooses how many bytes the window is moved. The result is taken little-endian from the joined pair: the older word supplies the low bytes and the newer word the high bytes.

The block keeps the previous word inside itself. A stream of n aligned words therefore costs n+1 input words. The first word only loads the internal register. A `prime` pulse marks the start of a new stream, so the next valid word is used only for loading. Results come out one clock after the word that produces them.

Top module: `byte_realign`

## Requirements
- R1: After reset `out_valid` and `out_data` are 0, the held previous word is 0, the byte index is 0, and the block waits for a priming word.
- R2: For a word accepted at a clock edge while the stream is live, `out_data` after that edge equals the low W bits of the concatenation {in_data, previous word} shifted right by 8 times the byte index. With index 2, previous word 0x03020100 and input 0x07060504 give 0x05040302.
- R3: The first valid word after reset, or after a `prime` pulse, produces no `out_valid` and is only stored as the previous word.
- R4: Every later valid word in the same stream produces exactly one `out_valid` pulse in the cycle after it is accepted. This holds for back-to-back words and for words separated by idle cycles.
- R5: Every accepted word is stored as the previous word, including priming words. The next result is always built from the word accepted just before it.
- R6: The byte index is loaded from `cfg_idx` when `cfg_we` is high and then keeps that value. A word accepted in the same cycle as an index write still uses the old index.
- R7: When `prime` and `in_valid` are high in the same cycle, that word counts as the priming word of a new stream: no output is produced and the word is stored.
- R8: In a cycle without `in_valid`, no output pulse follows, `out_data` holds its value, and the stored previous word is unchanged.
- R9: With byte index 0 the result is the previous word, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the byte index |
| cfg_idx | input | IDX_W | New byte index, taken when `cfg_we` is high |
| prime | input | 1 | Start a new stream; the next valid word only primes |
| in_valid | input | 1 | Input word present |
| in_data | input | 8*WORD_BYTES | Input word |
| out_valid | output | 1 | Aligned word present, one cycle after its input |
| out_data | output | 8*WORD_BYTES | Aligned word; holds between pulses |

## Verification
The bench builds the block with the default of four bytes per word. With that setting the 2-bit index covers every shift from zero to three bytes, including the widest case, where only one byte comes from the older word. Its scoreboard model carries its own previous word, stream phase and index. This puts every interaction within reach: priming combined with valid data, index writes in the same cycle as a word, and idle gaps inside a stream. These are exercised by directed streams and by a long pseudo-random stream.

// File: rtl/byte_realign_pkg.sv
package byte_realign_pkg;

    // Stream phase: waiting for the word that loads the history, or producing.
    typedef enum logic {
        PH_PRIME = 1'b0,
        PH_LIVE  = 1'b1
    } phase_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/realign_phase.sv
module realign_phase
    import byte_realign_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prime,
    input  logic in_valid,
    output logic fire
);

    phase_e phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        fire    = 1'b0;
        if (in_valid) begin
            // a word arriving with prime becomes the priming word
            fire    = (phase_q == PH_LIVE) && !prime;
            phase_d = PH_LIVE;
        end else if (prime) begin
            phase_d = PH_PRIME;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_PRIME;
        else        phase_q <= phase_d;
    end

    AST_WORD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (phase_q == PH_LIVE));                          // R5
    AST_PRIME_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (prime && !in_valid) |=> (phase_q == PH_PRIME));             // R3

endmodule

// File: rtl/realign_extract.sv
module realign_extract
    import byte_realign_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
    localparam int WORD_W = WORD_BYTES * BYTE_W
) (
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] prev_word,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] result
);

    localparam int POOL_N = 2 * WORD_BYTES;

    logic [BYTE_W-1:0] pool [POOL_N];

    // Older word fills the low half of the pool, newer word the high half.
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_pool
        assign pool[k]              = prev_word[k*BYTE_W +: BYTE_W];
        assign pool[k + WORD_BYTES] = cur_word[k*BYTE_W +: BYTE_W];
    end

    // Each output byte takes the pool byte idx positions above it.
    for (genvar j = 0; j < WORD_BYTES; j++) begin : g_pick
        always_comb begin
            result[j*BYTE_W +: BYTE_W] = pool[j + int'(idx)];
        end
    end

endmodule

// File: rtl/byte_realign.sv
module byte_realign
    import byte_realign_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
    localparam int WORD_W = WORD_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              prime,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    typedef struct packed {
        logic [WORD_W-1:0] prev;
        logic [WORD_W-1:0] odata;
        logic              ovalid;
        logic [IDX_W-1:0]  idx;
    } state_t;

    state_t st_d, st_q;
    logic              fire;
    logic [WORD_W-1:0] aligned;

    realign_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .prime    (prime),
        .in_valid (in_valid),
        .fire     (fire)
    );

    realign_extract #(.WORD_BYTES(WORD_BYTES)) u_extract (
        .cur_word  (in_data),
        .prev_word (st_q.prev),
        .idx       (st_q.idx),
        .result    (aligned)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ovalid = fire;
        if (fire)     st_d.odata = aligned;
        if (in_valid) st_d.prev  = in_data;
        if (cfg_we)   st_d.idx   = cfg_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ovalid;
    assign out_data  = st_q.odata;

    AST_PRIME_WORD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (prime && in_valid) |=> !out_valid);                         // R7
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                   // R8
    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(st_q.prev)));    // R8
    AST_IDX_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q.idx));                              // R6
    AST_WORD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (st_q.prev == $past(in_data)));                 // R5

endmodule

// File: tb/byte_realign_tb_top.sv
module byte_realign_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB     = 4;
    localparam int W      = NB * 8;
    localparam int IW     = 2;
    localparam int WD_MAX = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic          prime = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          out_valid;
    logic [W-1:0]  out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] exp_q [$];
    string        tag_q [$];
    string        cur_tag = "R1";

    // model state
    logic [W-1:0]  m_prev  = '0;
    logic          m_live  = 1'b0;
    logic [IW-1:0] m_idx   = '0;

    byte_realign #(.WORD_BYTES(NB)) dut_i (
        .clk, .rst_n, .cfg_we, .cfg_idx, .prime,
        .in_valid, .in_data, .out_valid, .out_data
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] model_align(logic [W-1:0] cur, logic [W-1:0] prv,
                                                 logic [IW-1:0] ix);
        logic [2*W-1:0] cat;
        cat = {cur, prv};
        return cat[W-1:0] >> 0 | W'(cat >> (8 * int'(ix)));
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one word; w_prime raises prime together with it, w_cfg writes idx in the same cycle
    task automatic send(logic [W-1:0] w, bit w_prime = 0, bit w_cfg = 0,
                        logic [IW-1:0] new_idx = '0, string tag = "R2");
        @(negedge clk);
        in_valid = 1'b1; in_data = w; prime = w_prime;
        cfg_we = w_cfg; cfg_idx = new_idx;
        cur_tag = tag;
        if (m_live && !w_prime) begin
            exp_q.push_back(W'(({w, m_prev}) >> (8 * int'(m_idx))));
            tag_q.push_back(tag);
        end
        m_prev = w;
        m_live = 1'b1;
        if (w_cfg) m_idx = new_idx;
    endtask

    task automatic idle(int n, bit do_prime = 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; cfg_we = 1'b0;
            prime = (i == 0) ? do_prime : 1'b0;
            cur_tag = "R8";
            if (i == 0 && do_prime) m_live = 1'b0;
        end
        @(negedge clk);
        prime = 1'b0;
    endtask

    task automatic set_idx(logic [IW-1:0] v);
        @(negedge clk);
        in_valid = 1'b0; prime = 1'b0;
        cfg_we = 1'b1; cfg_idx = v;
        cur_tag = "R6";
        m_idx = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // monitor: every cycle compares pulse presence and data against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !done) begin
                if (exp_q.size() > 0) begin
                    logic [W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " R4 pulse"}, W'(out_valid), W'(1));
                    check(t, out_data, e);
                end else if (out_valid) begin
                    n_cmp++; n_bad++;
                    $display("FAIL %s R3: unexpected out_valid actual 1 expected 0", cur_tag);
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < WD_MAX; c++) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] lf;
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        check("R1 out_valid", W'(out_valid), W'(0));
        check("R1 out_data", out_data, '0);
        rst_n = 1'b1;

        // R1 R9: index is 0 after reset, so the output is the previous word
        send(32'h0302_0100, 0, 0, '0, "R3");
        send(32'h0706_0504, 0, 0, '0, "R9");
        send(32'h0B0A_0908, 0, 0, '0, "R9");
        idle(2);

        // R2: index 2 stream of the worked example, after a fresh prime
        set_idx(2'd2);
        idle(1, 1);
        send(32'h0302_0100, 0, 0, '0, "R3");
        send(32'h0706_0504);
        send(32'h0B0A_0908);
        send(32'h0F0E_0D0C);
        idle(2);
        check("R2 literal", out_data, 32'h0D0C_0B0A);

        // R4 R8: index 1 with gaps inside the stream
        set_idx(2'd1);
        send(32'hAABB_CCDD, 0, 0, '0, "R4");
        idle(3);
        send(32'h1122_3344, 0, 0, '0, "R8");
        idle(1);
        send(32'h5566_7788, 0, 0, '0, "R5");
        idle(2);

        // R7: prime with a word mid-stream, index 3
        set_idx(2'd3);
        send(32'hDEAD_BEEF, 0, 0, '0, "R4");
        send(32'hCAFE_F00D, 1, 0, '0, "R7");
        send(32'h0123_4567, 0, 0, '0, "R7");
        send(32'h89AB_CDEF, 0, 0, '0, "R7");
        idle(2);

        // R6: index written in the same cycle as a word; that word uses the old index
        send(32'h1357_9BDF, 0, 1, 2'd1, "R6");
        send(32'h2468_ACE0, 0, 0, '0, "R6");
        idle(2);

        // R3: prime pulse alone, then a priming word must stay silent
        idle(1, 1);
        send(32'hFFFF_0000, 0, 0, '0, "R3");
        idle(2);

        // mixed stream with index changes
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[W-2:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (i % 7 == 3) send(lf, 0, 1, lf[1:0], "R6");
            else if (i % 13 == 5) send(lf, 1, 0, '0, "R7");
            else send(lf, 0, 0, '0, "R2");
            if (i % 9 == 4) idle(1);
        end
        idle(3);

        check("R4 queue drained", W'(exp_q.size()), W'(0));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule